// File: doc/BRIEF.md
# Four-Digit Multiplexed Seven-Segment Scanner

This block lights a four-digit common-anode seven-segment display from one shared set of seven cathode lines. Each digit has its own enable line, and only one enable is active at a time. The block takes four 4-bit values and shows each one as a hexadecimal character. It steps through the digits in a fixed, endless rotation, fast enough that all four digits look steady.

A free-running clock divider sets how long each digit stays on. That dwell time is derived from two parameters: the clock frequency and the dwell time in microseconds. The defaults give 1 ms per digit, so each digit is refreshed every 4 ms. That falls inside the required refresh window of 1 ms to 16 ms per digit. The enable lines and the cathode lines are both active low. Both are registered and change on the same clock edge, so a digit never shows the pattern meant for the digit next to it.

Top module: `digit_scanner`

## Requirements
- R1: Outside reset, and from the first clock edge after reset is released, exactly one bit of `anodeN` is 0 at every clock cycle.
- R2: On the first clock edge with `rst` low after a reset, digit 0 is enabled (`anodeN` = 4'b1110). It stays enabled for exactly DWELL_CYC cycles.
- R3: Digits are enabled in the order 0, 1, 2, 3, 0, and so on. Digit i is enabled by `anodeN[i]` = 0. Each digit stays enabled for exactly DWELL_CYC consecutive cycles, so one full frame takes 4 × DWELL_CYC cycles.
- R4: Cathodes are active low, with segment a on bit 6 down to segment g on bit 0. The lit (active-high) patterns for values 0 to F are: 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B, 77, 1F, 4E, 3D, 4F, 47. The value for digit i is `digitsIn[4i+3:4i]`.
- R5: When the enable moves to the next digit, `segN` shows that digit's pattern in the same cycle.
- R6: Reset is synchronous and active high. On a clock edge where `rst` is 1, all bits of `anodeN` and `segN` go to 1, and the scan restarts. A reset in the middle of a dwell restarts the scan at digit 0 once reset is released.
- R7: If the value of the enabled digit changes, `segN` shows the new pattern on the next clock edge, without waiting for the next dwell.
- R8: DWELL_CYC = (CLK_HZ / 1,000,000) × DWELL_US. With the defaults (250 MHz, 1000 µs), each digit is refreshed every 4 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| digitsIn | input | 16 | Four 4-bit values; digit i in bits 4i+3:4i |
| anodeN | output | 4 | Digit enables, active low, one per digit |
| segN | output | 7 | Shared cathodes, active low, a on bit 6 to g on bit 0 |

## Verification
The hardest cases to reach from the ports are the exact dwell boundaries, a value change in the middle of a dwell, and a reset that lands part-way through a digit. The bench keeps its own count of cycles since reset was released. For every cycle it works out which digit should be enabled and which pattern should be shown, and it queues that expectation. The stimulus changes the digit values in the middle of a dwell, and it asserts reset in the middle of a dwell and then releases it. The expected data steps through all sixteen characters. The bench runs with a small dwell, so many digit transitions happen within a short run.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic blank;    // force every output off and prime the index
    logic advance;  // move to the next digit on this edge
  } scan_strobe_t;

  localparam int SEG_W = 7;
  localparam int NIB_W = 4;

endpackage

// File: rtl/hex_glyph.sv
module hex_glyph
  import scan_pkg::*;
(
  input  logic [NIB_W-1:0] nibble,
  output logic [SEG_W-1:0] segs    // active high, a at bit 6 .. g at bit 0
);

  always_comb begin
    unique case (nibble)
      4'h0: segs = 7'h7E;
      4'h1: segs = 7'h30;
      4'h2: segs = 7'h6D;
      4'h3: segs = 7'h79;
      4'h4: segs = 7'h33;
      4'h5: segs = 7'h5B;
      4'h6: segs = 7'h5F;
      4'h7: segs = 7'h70;
      4'h8: segs = 7'h7F;
      4'h9: segs = 7'h7B;
      4'hA: segs = 7'h77;
      4'hB: segs = 7'h1F;
      4'hC: segs = 7'h4E;
      4'hD: segs = 7'h3D;
      4'hE: segs = 7'h4F;
      default: segs = 7'h47;
    endcase
  end

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int DWELL_CYC = 250000
) (
  input  logic         clk,
  input  logic         rst,
  output scan_strobe_t strobe
);

  localparam int CNT_W = (DWELL_CYC > 2) ? $clog2(DWELL_CYC) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(DWELL_CYC - 1);

  logic [CNT_W-1:0] divCnt;

  // Reset parks the divider at terminal count so the first live edge
  // both rolls it to zero and lands the scan on digit 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= TERM;
    end else if (divCnt == TERM) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.blank   = rst;
    strobe.advance = !rst && (divCnt == TERM);
  end

endmodule

// File: rtl/scan_dpath.sv
module scan_dpath
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                        clk,
  input  scan_strobe_t                strobe,
  input  logic [NUM_DIGITS*NIB_W-1:0] digitsIn,
  output logic [NUM_DIGITS-1:0]       anodeN,
  output logic [SEG_W-1:0]            segN
);

  localparam int IDX_W = (NUM_DIGITS > 2) ? $clog2(NUM_DIGITS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DIGITS - 1);
  localparam logic [NUM_DIGITS-1:0] ONE = NUM_DIGITS'(1);

  logic [SEG_W-1:0] glyphs [NUM_DIGITS];
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idxNext;

  genvar g;
  generate
    for (g = 0; g < NUM_DIGITS; g++) begin : g_dec
      hex_glyph u_glyph (
        .nibble (digitsIn[g*NIB_W +: NIB_W]),
        .segs   (glyphs[g])
      );
    end
  endgenerate

  always_comb begin
    if (strobe.blank) begin
      idxNext = LAST;
    end else if (strobe.advance) begin
      idxNext = (idx == LAST) ? '0 : idx + 1'b1;
    end else begin
      idxNext = idx;
    end
  end

  // Enable and cathodes are loaded from the same next index on the same edge
  always_ff @(posedge clk) begin
    idx <= idxNext;
    if (strobe.blank) begin
      anodeN <= '1;
      segN   <= '1;
    end else begin
      anodeN <= ~(ONE << idxNext);
      segN   <= ~glyphs[idxNext];
    end
  end

endmodule

// File: rtl/digit_scanner.sv
module digit_scanner
  import scan_pkg::*;
#(
  parameter int CLK_HZ     = 250_000_000,
  parameter int DWELL_US   = 1000,
  parameter int NUM_DIGITS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_DIGITS*NIB_W-1:0] digitsIn,
  output logic [NUM_DIGITS-1:0]       anodeN,
  output logic [SEG_W-1:0]            segN
);

  localparam int DWELL_CYC = (CLK_HZ / 1_000_000) * DWELL_US;

  scan_strobe_t strobe;

  scan_ctrl #(
    .DWELL_CYC (DWELL_CYC)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  scan_dpath #(
    .NUM_DIGITS (NUM_DIGITS)
  ) u_dpath (
    .clk      (clk),
    .strobe   (strobe),
    .digitsIn (digitsIn),
    .anodeN   (anodeN),
    .segN     (segN)
  );

endmodule

// File: rtl/scan_chk.sv
module scan_chk #(
  parameter int NUM_DIGITS = 4,
  parameter int DWELL_CYC  = 250000
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_DIGITS-1:0] anodeN,
  input logic [6:0]            segN
);

  logic [NUM_DIGITS-1:0] prevAn;
  logic [31:0]           holdCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevAn  <= '1;
      holdCnt <= '0;
    end else begin
      prevAn  <= anodeN;
      holdCnt <= (anodeN != prevAn) ? 32'd0 : holdCnt + 32'd1;
    end
  end

  // R1
  one_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(~anodeN) == 1);

  // R6
  reset_blank_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (anodeN == '1 && segN == '1));

  // R3
  rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (anodeN != $past(anodeN) && $past(anodeN) != '1 && anodeN != '1)
      |-> anodeN == {$past(anodeN[NUM_DIGITS-2:0]), $past(anodeN[NUM_DIGITS-1])});

  // R3
  dwell_max_chk: assert property (@(posedge clk) disable iff (rst)
    holdCnt < 32'(DWELL_CYC));

  // R3
  dwell_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (anodeN != prevAn && prevAn != '1 && anodeN != '1) |-> holdCnt == 32'(DWELL_CYC - 1));

  // R4
  lit_chk: assert property (@(posedge clk) disable iff (rst)
    (anodeN != '1) |-> segN != 7'h7F);

endmodule

bind digit_scanner scan_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .DWELL_CYC  (DWELL_CYC)
) u_scan_chk (
  .clk    (clk),
  .rst    (rst),
  .anodeN (anodeN),
  .segN   (segN)
);

// File: tb/sim_digit_scanner.sv
`timescale 1ns/1ps
module sim_digit_scanner;

  localparam int CLK_HZ   = 2_000_000;
  localparam int DWELL_US = 3;
  localparam int ND       = 4;
  // R8: dwell in cycles from the clock rate and dwell time
  localparam int D = (CLK_HZ / 1_000_000) * DWELL_US;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] digits = '0;
  logic [3:0]  anodeN;
  logic [6:0]  segN;

  always #2 clk = ~clk;

  digit_scanner #(
    .CLK_HZ     (CLK_HZ),
    .DWELL_US   (DWELL_US),
    .NUM_DIGITS (ND)
  ) u0 (
    .clk      (clk),
    .rst      (rst),
    .digitsIn (digits),
    .anodeN   (anodeN),
    .segN     (segN)
  );

  typedef struct {
    logic [3:0] an;
    logic [6:0] seg;
    string      tA;
    string      tS;
    bit         one;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   k      = 0;

  // R4: lit pattern per value, a at bit 6
  function automatic logic [6:0] glyph(input logic [3:0] v);
    case (v)
      4'h0: return 7'h7E;  4'h1: return 7'h30;  4'h2: return 7'h6D;  4'h3: return 7'h79;
      4'h4: return 7'h33;  4'h5: return 7'h5B;  4'h6: return 7'h5F;  4'h7: return 7'h70;
      4'h8: return 7'h7F;  4'h9: return 7'h7B;  4'hA: return 7'h77;  4'hB: return 7'h1F;
      4'hC: return 7'h4E;  4'hD: return 7'h3D;  4'hE: return 7'h4F;  default: return 7'h47;
    endcase
  endfunction

  task automatic drive(input bit r, input logic [15:0] dv, input string segTag);
    exp_t e;
    int   dg;
    @(negedge clk);
    rst    = r;
    digits = dv;
    if (r) begin
      e.an = 4'hF; e.seg = 7'h7F; e.tA = "R6"; e.tS = "R6"; e.one = 1'b0;
      k = 0;
    end else begin
      dg    = (k / D) % ND;
      e.an  = ~(4'b0001 << dg);
      e.seg = ~glyph(dv[dg*4 +: 4]);
      e.tA  = (k < D) ? "R2" : ((k == D) ? "R8" : "R3");
      e.tS  = (segTag != "") ? segTag : (((k % D) == 0) ? "R5" : "R4");
      e.one = 1'b1;
      k++;
    end
    q.push_back(e);
  endtask

  task automatic run(input int n, input logic [15:0] dv, input string segTag);
    for (int i = 0; i < n; i++) drive(1'b0, dv, (i == 0) ? segTag : "");
  endtask

  task automatic doReset(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 16'h0000, "");
  endtask

  // Monitor: compare each queued expectation one step after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (anodeN !== e.an) begin
          fails++;
          $display("FAIL %s anodeN actual %b expected %b", e.tA, anodeN, e.an);
        end
        checks++;
        if (segN !== e.seg) begin
          fails++;
          $display("FAIL %s segN actual %h expected %h", e.tS, segN, e.seg);
        end
        if (e.one) begin
          checks++;
          if ($countones(~anodeN) != 1) begin
            fails++;
            $display("FAIL R1 anodeN actual %b expected one low bit", anodeN);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset(3);                     // R6 reset state
    run(2 * ND * D, 16'h3210, "");  // R2, R3, R5, R8 first frames
    run(ND * D, 16'h7654, "");      // R4 glyphs 4..7
    run(ND * D, 16'hBA98, "");      // R4 glyphs 8..B
    run(ND * D, 16'hFEDC, "");      // R4 glyphs C..F
    run(2, 16'hFEDC, "");
    run(1, 16'h5A5A, "R7");         // R7 mid-dwell value change
    run(ND * D + 3, 16'h5A5A, "");
    doReset(2);                     // R6 reset in the middle of a dwell
    run(2 * ND * D, 16'h0F1E, "");  // R2 restart at digit 0
    repeat (3) @(posedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule